// File: doc/BRIEF.md
# Banked GPIO Controller with Relocatable Data Window

This block is the general-purpose I/O function of a configuration-port style peripheral. It has 64 pins, organised as 8 groups of 8. Software sets it up through an index/data configuration port. One index selects the active logical device. The other configuration registers, which hold the base address, direction, function select and polarity, can be reached only while this block's device number is selected.

At run time, software reads pin levels and writes output latches through a separate window of 8 consecutive I/O addresses. The window starts at the programmed base address and has one address per group. The pads appear as plain vectors: the level seen at the pad, the value driven, the output enable, and an alternate-function source for each pin.

Both read paths are combinational. A write takes effect at the next rising clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all output enables are 0, all output latches are 0, the base address is 0, every simple-I/O select bit is 1, and every polarity bit is 0. As a result, `pad_oe` and `pad_out` are both all zero.
- R2: Configuration port, when `cfg_sel`=0: a write loads the index register, and a read returns it. When `cfg_sel`=1, a write updates the register addressed by the current index. A read returns that register combinationally, in the same cycle. Every write lands at the next rising edge.
- R3: Index 0x07 holds the selected device number and is always accessible. All other indices respond only while it holds 7. Otherwise, writes to them are ignored and reads return 0.
- R4: Index 0x62 holds the high byte of the 16-bit base address and index 0x63 holds the low byte. The data window is decoded only while the base is nonzero. While the base is zero, every window read returns 0 and every window write is ignored.
- R5: Window address base+g (g in 0..7) reads and writes group g, with data bit b mapping to pin 8·g+b. A write loads the output latches of that group. An address outside base..base+7 reads 0, and a write to it changes no latch.
- R6: Index 0xC8+g holds the output enables of group g (g in 0..7). A 1 makes the pin an output, so its `pad_oe` bit is 1.
- R7: Index 0xC0+g holds the simple-I/O selects of group g, for g in 0..4 only. A clear bit makes `pad_out` follow `alt_in` for that pin, and the window read returns the raw `pad_in` level. Groups 5..7 always behave as simple I/O.
- R8: Index 0xB0+g holds polarity bits for group g, for g in 0..4. A set bit on a simple-I/O pin inverts both the driven latch value and the value read from `pad_in`.
- R9: Indices with no register behind them read 0 and ignore writes. This includes 0xB5..0xBF and 0xC5..0xC7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration port write strobe |
| cfg_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | 16 | Run-time I/O address |
| io_we | input | 1 | Run-time write strobe |
| io_wdata | input | 8 | Run-time write data |
| io_rdata | output | 8 | Run-time read data (combinational, 0 when no hit) |
| pad_in | input | 64 | Pad input levels |
| alt_in | input | 64 | Alternate-function drive values |
| pad_out | output | 64 | Pad drive values |
| pad_oe | output | 64 | Pad output enables |

## Verification
The bench builds the block with its default parameters: 8 groups, 5 of them with programmable function and polarity, and device number 7. At this size every group index, every configuration register and every window offset can be swept in full. Each group gets a distinct arithmetic pattern, so a swapped group, a swapped bit or a wrong register offset shows up as a mismatch. The sweeps also cover the edges of the window on both sides, the two ranges where a register exists only for the lower groups, a relocated base, and the zero-base disable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Configuration index map; offsets are decoded by software and by the port logic
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] IDX_BASE_LO = 8'h63;
    localparam logic [7:0] IDX_POL0    = 8'hB0;
    localparam logic [7:0] IDX_SE0     = 8'hC0;
    localparam logic [7:0] IDX_OE0     = 8'hC8;
    localparam int         GRP_W       = 8;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int         NGROUPS = 8,
    parameter int         NPROG   = 5,
    parameter logic [7:0] DEV_ID  = 8'h07,
    localparam int        NPINS   = NGROUPS * GRP_W,
    localparam int        NPB     = NPROG * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic [NPINS-1:0] oe_o,
    output logic [NPINS-1:0] se_o,
    output logic [NPINS-1:0] pol_o,
    output logic [15:0]      base_o
);
    typedef struct packed {
        logic [7:0]       idx;
        logic [7:0]       ldn;
        logic [15:0]      base;
        logic [NPINS-1:0] oe;
        logic [NPB-1:0]   se;
        logic [NPB-1:0]   pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic dev_ok;

    assign dev_ok = (cfg_q.ldn == DEV_ID);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && !cfg_sel) begin
            cfg_d.idx = cfg_wdata;
        end else if (cfg_we && cfg_sel) begin
            if (cfg_q.idx == IDX_LDN) begin
                cfg_d.ldn = cfg_wdata;
            end else if (dev_ok) begin
                if (cfg_q.idx == IDX_BASE_HI) cfg_d.base[15:8] = cfg_wdata;
                if (cfg_q.idx == IDX_BASE_LO) cfg_d.base[7:0]  = cfg_wdata;
                for (int g = 0; g < NGROUPS; g++)
                    if (cfg_q.idx == IDX_OE0 + 8'(g)) cfg_d.oe[g*GRP_W +: GRP_W] = cfg_wdata;
                for (int g = 0; g < NPROG; g++) begin
                    if (cfg_q.idx == IDX_SE0 + 8'(g))  cfg_d.se[g*GRP_W +: GRP_W]  = cfg_wdata;
                    if (cfg_q.idx == IDX_POL0 + 8'(g)) cfg_d.pol[g*GRP_W +: GRP_W] = cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (!cfg_sel) begin
            cfg_rdata = cfg_q.idx;
        end else if (cfg_q.idx == IDX_LDN) begin
            cfg_rdata = cfg_q.ldn;
        end else if (dev_ok) begin
            if (cfg_q.idx == IDX_BASE_HI) cfg_rdata = cfg_q.base[15:8];
            if (cfg_q.idx == IDX_BASE_LO) cfg_rdata = cfg_q.base[7:0];
            for (int g = 0; g < NGROUPS; g++)
                if (cfg_q.idx == IDX_OE0 + 8'(g)) cfg_rdata = cfg_q.oe[g*GRP_W +: GRP_W];
            for (int g = 0; g < NPROG; g++) begin
                if (cfg_q.idx == IDX_SE0 + 8'(g))  cfg_rdata = cfg_q.se[g*GRP_W +: GRP_W];
                if (cfg_q.idx == IDX_POL0 + 8'(g)) cfg_rdata = cfg_q.pol[g*GRP_W +: GRP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.se   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign oe_o   = cfg_q.oe;
    assign base_o = cfg_q.base;

    generate
        if (NPROG < NGROUPS) begin : g_partial
            assign se_o  = {{(NPINS-NPB){1'b1}}, cfg_q.se};
            assign pol_o = {{(NPINS-NPB){1'b0}}, cfg_q.pol};
        end else begin : g_full
            assign se_o  = cfg_q.se;
            assign pol_o = cfg_q.pol;
        end
    endgenerate

    AST_BASE_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && dev_ok && cfg_q.idx == IDX_BASE_HI)
        |=> base_o[15:8] == $past(cfg_wdata)); // R4
    AST_FOREIGN_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && !dev_ok && cfg_q.idx != IDX_LDN)
        |=> ($stable(oe_o) && $stable(se_o) && $stable(pol_o) && $stable(base_o))); // R3
    AST_IDLE_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(oe_o) && $stable(base_o) && $stable(pol_o))); // R2
endmodule

// File: rtl/gpio_data_window.sv
module gpio_data_window
    import gpio_bank_pkg::*;
#(
    parameter int  NGROUPS = 8,
    localparam int NPINS   = NGROUPS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      base_i,
    input  logic [15:0]      io_addr,
    input  logic             io_we,
    input  logic [7:0]       io_wdata,
    input  logic [NPINS-1:0] rd_val_i,
    output logic [7:0]       io_rdata,
    output logic [NPINS-1:0] latch_o
);
    localparam logic [15:0] NG16 = 16'(NGROUPS);

    logic [NPINS-1:0] latch_d, latch_q;
    logic [15:0]      off;
    logic             hit;

    assign off = io_addr - base_i;
    assign hit = (base_i != 16'h0) && (io_addr >= base_i) && (off < NG16);

    always_comb begin
        latch_d  = latch_q;
        io_rdata = 8'h00;
        for (int g = 0; g < NGROUPS; g++) begin
            if (hit && off == 16'(g)) begin
                io_rdata = rd_val_i[g*GRP_W +: GRP_W];
                if (io_we) latch_d[g*GRP_W +: GRP_W] = io_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    assign latch_o = latch_q;

    AST_ZERO_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (base_i == 16'h0) |-> io_rdata == 8'h00); // R4
    AST_IDLE_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !io_we |=> $stable(latch_o)); // R5
    AST_MISS_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && (io_addr < base_i || (io_addr - base_i) >= NG16)) |=> $stable(latch_o)); // R5
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPINS = 64
) (
    input  logic [NPINS-1:0] latch_i,
    input  logic [NPINS-1:0] oe_i,
    input  logic [NPINS-1:0] se_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] alt_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] rd_val_o
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            assign pad_out[i]  = se_i[i] ? (latch_i[i] ^ pol_i[i]) : alt_in[i];
            assign rd_val_o[i] = se_i[i] ? (pad_in[i] ^ pol_i[i]) : pad_in[i];
            assign pad_oe[i]   = oe_i[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int         NGROUPS = 8,
    parameter int         NPROG   = 5,
    parameter logic [7:0] DEV_ID  = 8'h07,
    localparam int        NPINS   = NGROUPS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [15:0]      io_addr,
    input  logic             io_we,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] alt_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic [NPINS-1:0] oe_w, se_w, pol_w, latch_w, rd_w;
    logic [15:0]      base_w;

    gpio_cfg_regs #(.NGROUPS(NGROUPS), .NPROG(NPROG), .DEV_ID(DEV_ID)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .oe_o(oe_w), .se_o(se_w), .pol_o(pol_w), .base_o(base_w)
    );

    gpio_data_window #(.NGROUPS(NGROUPS)) u_win (
        .clk(clk), .rst_n(rst_n), .base_i(base_w), .io_addr(io_addr),
        .io_we(io_we), .io_wdata(io_wdata), .rd_val_i(rd_w),
        .io_rdata(io_rdata), .latch_o(latch_w)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .latch_i(latch_w), .oe_i(oe_w), .se_i(se_w), .pol_i(pol_w),
        .pad_in(pad_in), .alt_in(alt_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .rd_val_o(rd_w)
    );

    AST_OE_TRACKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(oe_w) |-> $stable(pad_oe)); // R6
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = 8'h0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = 16'h0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [63:0] pad_in = 64'hC3A5_0F96_5A3C_E187;
    logic [63:0] alt_in = 64'h1234_5678_9ABC_DEF0;
    logic [63:0] pad_out, pad_oe;

    int checks = 0, errors = 0;
    logic [63:0] m_oe = '0, m_se = '1, m_pol = '0, m_lat = '0;
    logic [15:0] base = 16'h0;
    logic [7:0]  rv;

    always #2 clk = ~clk;

    gpio_bank_ctrl u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] v);
        @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = i;
        @(negedge clk); cfg_sel = 1; cfg_wdata = v;
        @(negedge clk); cfg_we = 0; #1;
    endtask

    task automatic cfg_rd(input logic [7:0] i, output logic [7:0] v);
        @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = i;
        @(negedge clk); cfg_we = 0; cfg_sel = 1; #1; v = cfg_rdata;
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_we = 1;
        @(negedge clk); io_we = 0; #1;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_we = 0; #1; d = io_rdata;
    endtask

    function automatic logic [63:0] exp_out();
        for (int i = 0; i < 64; i++)
            exp_out[i] = m_se[i] ? (m_lat[i] ^ m_pol[i]) : alt_in[i];
    endfunction

    function automatic logic [7:0] exp_rd(input int g);
        for (int b = 0; b < 8; b++)
            exp_rd[b] = m_se[g*8+b] ? (pad_in[g*8+b] ^ m_pol[g*8+b]) : pad_in[g*8+b];
    endfunction

    task automatic check_reads(input string req);
        for (int g = 0; g < 8; g++) begin
            io_rd(base + 16'(g), rv);
            chk(req, 64'(rv), 64'(exp_rd(g)));
        end
    endtask

    initial begin
        #(4*150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        io_rd(16'h0000, rv);
        chk("R4 zero base read", 64'(rv), 64'h0);

        // R2 index register readback
        @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'h5C;
        @(negedge clk); cfg_we = 0; #1;
        chk("R2 index readback", 64'(cfg_rdata), 64'h5C);

        // R3 foreign device blocks access
        cfg_wr(8'h07, 8'h03);
        cfg_wr(8'hC8, 8'hFF);
        chk("R3 oe unchanged", pad_oe, '0);
        cfg_rd(8'hC8, rv); chk("R3 foreign read", 64'(rv), 64'h0);
        cfg_rd(8'h07, rv); chk("R2 ldn readback", 64'(rv), 64'h03);
        cfg_wr(8'h07, 8'h07);
        cfg_rd(8'hC8, rv); chk("R3 selected read", 64'(rv), 64'h0);
        cfg_rd(8'h62, rv); chk("R1 base hi", 64'(rv), 64'h0);
        cfg_rd(8'h63, rv); chk("R1 base lo", 64'(rv), 64'h0);

        // R4 program base
        cfg_wr(8'h62, 8'h0A); cfg_wr(8'h63, 8'h10); base = 16'h0A10;
        cfg_rd(8'h62, rv); chk("R4 base hi", 64'(rv), 64'h0A);
        cfg_rd(8'h63, rv); chk("R4 base lo", 64'(rv), 64'h10);

        // R6 output enable sweep
        for (int g = 0; g < 8; g++) begin
            logic [7:0] v;
            v = 8'h5A ^ 8'(g*37);
            cfg_wr(8'hC8 + 8'(g), v);
            m_oe[g*8 +: 8] = v;
            chk("R6 pad_oe", pad_oe, m_oe);
            cfg_rd(8'hC8 + 8'(g), rv); chk("R6 oe readback", 64'(rv), 64'(v));
        end

        // R5 latch sweep and reads
        for (int g = 0; g < 8; g++) begin
            logic [7:0] v;
            v = 8'(g*29 + 3);
            io_wr(base + 16'(g), v);
            m_lat[g*8 +: 8] = v;
            chk("R5 pad_out", pad_out, exp_out());
        end
        check_reads("R5 group read");
        io_rd(base - 16'd1, rv); chk("R5 below window", 64'(rv), 64'h0);
        io_rd(base + 16'd8, rv); chk("R5 above window", 64'(rv), 64'h0);
        io_wr(base + 16'd8, 8'hFF); chk("R5 above write ignored", pad_out, exp_out());
        io_wr(base - 16'd1, 8'hFF); chk("R5 below write ignored", pad_out, exp_out());

        // R8 polarity sweep
        for (int g = 0; g < 5; g++) begin
            logic [7:0] v;
            v = 8'h96 ^ 8'(g*11);
            cfg_wr(8'hB0 + 8'(g), v);
            m_pol[g*8 +: 8] = v;
            chk("R8 pad_out", pad_out, exp_out());
        end
        check_reads("R8 inverted read");

        // R9 unmapped indices
        cfg_wr(8'hB5, 8'hAA); cfg_rd(8'hB5, rv); chk("R9 B5 read", 64'(rv), 64'h0);
        chk("R9 B5 no effect", pad_out, exp_out());
        cfg_wr(8'hC5, 8'h00); cfg_rd(8'hC5, rv); chk("R9 C5 read", 64'(rv), 64'h0);
        chk("R9 C5 no effect", pad_out, exp_out());

        // R7 simple-I/O select sweep
        for (int g = 0; g < 5; g++) begin
            logic [7:0] v;
            v = 8'hF0 ^ 8'(g*53);
            cfg_wr(8'hC0 + 8'(g), v);
            m_se[g*8 +: 8] = v;
            chk("R7 pad_out", pad_out, exp_out());
        end
        check_reads("R7 mixed read");
        pad_in = ~pad_in; alt_in = {alt_in[31:0], alt_in[63:32]};
        #1;
        chk("R7 alt follow", pad_out, exp_out());
        check_reads("R7 new pad read");

        // R4 relocation
        cfg_wr(8'h62, 8'h03); cfg_wr(8'h63, 8'h00); base = 16'h0300;
        io_rd(16'h0302, rv); chk("R4 relocated read", 64'(rv), 64'(exp_rd(2)));
        io_rd(16'h0A12, rv); chk("R4 old base dead", 64'(rv), 64'h0);

        // R4 zero base disables window
        cfg_wr(8'h62, 8'h00); cfg_wr(8'h63, 8'h00); base = 16'h0;
        for (int g = 0; g < 8; g++) begin
            io_rd(16'(g), rv); chk("R4 disabled read", 64'(rv), 64'h0);
            io_wr(16'(g), 8'h3C); chk("R4 disabled write", pad_out, exp_out());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule